// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block carries out one single-byte register transfer, a read or a write, against a target on a two-wire I2C bus. It does not move the wires itself. It sends a stream of bus primitives to a separate bit-level line engine: start condition, stop condition, send one bit, sample one bit, check acknowledge, release the data line, and one clock pulse. The engine answers each primitive with a completion strobe, an error flag and a sampled bit.

A caller presents a request with a direction, a device address byte, a register offset and, for writes, a data byte. The block holds busy high until the transfer ends and then gives a one-cycle done pulse together with a pass/fail status. A read also returns the byte it fetched.

Any failed bit or missing acknowledge ends the current attempt at once. The block then frees a stuck bus with a clock-pulse recovery sequence and waits out a long back-off period. After that it starts a fresh attempt, as long as the per-direction attempt budget allows one.

Top module: `i2c_regseq`

## Requirements
- R1: Every transmitted byte goes out as eight send-bit primitives, most significant bit first. A release primitive follows the eighth bit.
- R2: A successful read issues START, the address byte as given, ACK, the offset, ACK, START, the address byte with bit 0 forced to 1, ACK, eight sample-bit primitives, a send-bit of value 1, then STOP. The sampled bits form rd_data, first bit in the MSB.
- R3: A successful write issues START, the address byte as given, ACK, the offset, ACK, the data byte, ACK, then STOP. Each byte follows R1.
- R4: An error returned on a send-bit or ACK primitive ends the attempt. No further primitive of that attempt is issued, and recovery starts with the next primitive.
- R5: Recovery issues START, release, CLR_PULSES clock pulses, START and STOP, in that order. Errors returned on START, STOP, release or pulse primitives are ignored in every phase.
- R6: Between the end of recovery and the next attempt, prim_valid stays low for exactly BACKOFF_CYCLES+1 cycles.
- R7: A read gets at most READ_TRIES attempts (default 10). A write gets at most WRITE_TRIES attempts (default 1). After the last failed attempt, its recovery and back-off still run before done.
- R8: bb_en rises in the cycle after a request is accepted, stays high while busy is high, and falls together with busy.
- R9: rd_data reads 0 in the cycle after a read request is accepted. It is cleared again at the start of every read attempt and holds its value while the block is idle.
- R10: fail is 1 after done only if every allowed attempt failed. A later successful transfer returns it to 0. fail changes only in the done cycle.
- R11: req_valid is ignored while busy is high. The stream in progress is unchanged, and no second transfer follows it.
- R12: Primitive codes on prim_op are START=0, STOP=1, send-bit=2 (value on prim_bit), sample-bit=3, ACK=4, release=5, pulse=6. prim_valid, prim_op and prim_bit hold steady until prim_done is seen, and only one primitive is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_dev | input | 8 | Device address byte; bit 0 is the direction bit of the first address phase |
| req_offset | input | 8 | Register offset |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| fail | output | 1 | Outcome of the last transfer (1 = all attempts failed) |
| rd_data | output | 8 | Byte returned by the last read |
| bb_en | output | 1 | Line-engine enable, high for the whole transfer |
| prim_valid | output | 1 | Primitive request to the line engine |
| prim_op | output | 3 | Primitive code (see R12) |
| prim_bit | output | 1 | Bit value for send-bit primitives |
| prim_done | input | 1 | Line engine finished the current primitive |
| prim_err | input | 1 | Line engine reports bit-verify failure or missing acknowledge |
| prim_rbit | input | 1 | Bit sampled by a sample-bit primitive |

## Verification
The bench aborts attempts at different points to show that nothing from the aborted attempt leaks out after the error. These points are the first address acknowledge, a bit in the middle of the offset byte, and the read-address acknowledge. A design that finished the byte before aborting, or that skipped its release, would emit extra or missing primitives. The line engine flags errors on start, stop, release and pulse primitives, so a design that honoured those errors would abort successful transfers. A full run of ten failing read attempts, followed by a write, exposes off-by-one attempt budgets, back-off windows of the wrong length, and a fail status that sticks after a later success. A request poked in mid-transfer would show up as a changed primitive stream or a second done pulse.

// File: rtl/i2c_regseq_pkg.sv
package i2c_regseq_pkg;

   typedef enum logic [2:0] {
      P_START = 3'd0,
      P_STOP  = 3'd1,
      P_WBIT  = 3'd2,
      P_RBIT  = 3'd3,
      P_ACK   = 3'd4,
      P_REL   = 3'd5,
      P_PULSE = 3'd6
   } prim_e;

   typedef enum logic [3:0] {
      IT_START, IT_TX, IT_ACK, IT_RX, IT_NACK, IT_STOP, IT_REL, IT_PULSE, IT_END
   } item_e;

   typedef enum logic [1:0] {
      B_ADDR_W, B_OFF, B_ADDR_R, B_DATA
   } bsel_e;

   typedef struct packed {
      item_e kind;
      bsel_e sel;
   } item_t;

   typedef enum logic [1:0] {
      ST_IDLE, ST_ISSUE, ST_BACKOFF
   } st_e;

   localparam int unsigned IDX_W = 4;

endpackage

// File: rtl/i2c_regseq_script.sv
module i2c_regseq_script
   import i2c_regseq_pkg::*;
(
   input  logic             recover,
   input  logic             is_wr,
   input  logic [IDX_W-1:0] idx,
   output item_t            item
);

   function automatic item_t mk(item_e k, bsel_e s);
      item_t t;
      t.kind = k;
      t.sel  = s;
      return t;
   endfunction

   always_comb begin
      item = mk(IT_END, B_ADDR_W);
      if (recover) begin
         case (idx)
            4'd0:    item = mk(IT_START, B_ADDR_W);
            4'd1:    item = mk(IT_REL,   B_ADDR_W);
            4'd2:    item = mk(IT_PULSE, B_ADDR_W);
            4'd3:    item = mk(IT_START, B_ADDR_W);
            4'd4:    item = mk(IT_STOP,  B_ADDR_W);
            default: item = mk(IT_END,   B_ADDR_W);
         endcase
      end else if (is_wr) begin
         case (idx)
            4'd0:    item = mk(IT_START, B_ADDR_W);
            4'd1:    item = mk(IT_TX,    B_ADDR_W);
            4'd2:    item = mk(IT_ACK,   B_ADDR_W);
            4'd3:    item = mk(IT_TX,    B_OFF);
            4'd4:    item = mk(IT_ACK,   B_OFF);
            4'd5:    item = mk(IT_TX,    B_DATA);
            4'd6:    item = mk(IT_ACK,   B_DATA);
            4'd7:    item = mk(IT_STOP,  B_DATA);
            default: item = mk(IT_END,   B_ADDR_W);
         endcase
      end else begin
         case (idx)
            4'd0:    item = mk(IT_START, B_ADDR_W);
            4'd1:    item = mk(IT_TX,    B_ADDR_W);
            4'd2:    item = mk(IT_ACK,   B_ADDR_W);
            4'd3:    item = mk(IT_TX,    B_OFF);
            4'd4:    item = mk(IT_ACK,   B_OFF);
            4'd5:    item = mk(IT_START, B_ADDR_R);
            4'd6:    item = mk(IT_TX,    B_ADDR_R);
            4'd7:    item = mk(IT_ACK,   B_ADDR_R);
            4'd8:    item = mk(IT_RX,    B_ADDR_R);
            4'd9:    item = mk(IT_NACK,  B_ADDR_R);
            4'd10:   item = mk(IT_STOP,  B_ADDR_R);
            default: item = mk(IT_END,   B_ADDR_W);
         endcase
      end
   end

endmodule

// File: rtl/i2c_regseq_prim.sv
module i2c_regseq_prim
   import i2c_regseq_pkg::*;
#(
   parameter int unsigned CLR_PULSES = 9,
   parameter int unsigned SUB_W      = 4
) (
   input  item_t            item,
   input  logic [SUB_W-1:0] sub,
   input  logic [7:0]       dev,
   input  logic [7:0]       off,
   input  logic [7:0]       wd,
   output prim_e            op,
   output logic             bitv,
   output logic             last,
   output logic             chk,
   output logic             rx
);

   logic [7:0] tx_byte;

   always_comb begin
      case (item.sel)
         B_ADDR_W: tx_byte = dev;
         B_OFF:    tx_byte = off;
         B_ADDR_R: tx_byte = {dev[7:1], 1'b1};
         default:  tx_byte = wd;
      endcase
   end

   always_comb begin
      op   = P_START;
      bitv = 1'b0;
      last = 1'b1;
      chk  = 1'b0;
      rx   = 1'b0;
      case (item.kind)
         IT_START: op = P_START;
         IT_STOP:  op = P_STOP;
         IT_REL:   op = P_REL;
         IT_ACK: begin
            op  = P_ACK;
            chk = 1'b1;
         end
         IT_NACK: begin
            op   = P_WBIT;
            bitv = 1'b1;
            chk  = 1'b1;
         end
         IT_TX: begin
            if (sub < SUB_W'(8)) begin
               op   = P_WBIT;
               bitv = tx_byte[3'd7 - sub[2:0]];
               chk  = 1'b1;
               last = 1'b0;
            end else begin
               op = P_REL;
            end
         end
         IT_RX: begin
            op   = P_RBIT;
            rx   = 1'b1;
            last = (sub == SUB_W'(7));
         end
         IT_PULSE: begin
            op   = P_PULSE;
            last = (sub == SUB_W'(CLR_PULSES - 1));
         end
         default: op = P_START;
      endcase
   end

endmodule

// File: rtl/i2c_regseq_backoff.sv
module i2c_regseq_backoff #(
   parameter int unsigned CYCLES = 12_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);

   localparam int unsigned CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (load)            cnt <= CNT_W'(CYCLES - 1);
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
   import i2c_regseq_pkg::*;
#(
   parameter int unsigned READ_TRIES     = 10,
   parameter int unsigned WRITE_TRIES    = 1,
   parameter int unsigned CLR_PULSES     = 9,
   parameter int unsigned BACKOFF_CYCLES = 12_500_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_write,
   input  logic [7:0] req_dev,
   input  logic [7:0] req_offset,
   input  logic [7:0] req_wdata,
   output logic       busy,
   output logic       done,
   output logic       fail,
   output logic [7:0] rd_data,
   output logic       bb_en,
   output logic       prim_valid,
   output logic [2:0] prim_op,
   output logic       prim_bit,
   input  logic       prim_done,
   input  logic       prim_err,
   input  logic       prim_rbit
);

   localparam int unsigned MAX_TRIES = (READ_TRIES > WRITE_TRIES) ? READ_TRIES : WRITE_TRIES;
   localparam int unsigned TRY_W     = $clog2(MAX_TRIES + 1);
   localparam int unsigned SUB_MAX   = (CLR_PULSES > 8) ? CLR_PULSES : 8;
   localparam int unsigned SUB_W     = $clog2(SUB_MAX + 1);

   generate
      if (READ_TRIES < 1 || WRITE_TRIES < 1) begin : g_bad_tries
         $error("attempt limits must be at least 1");
      end
      if (CLR_PULSES < 1) begin : g_bad_pulses
         $error("CLR_PULSES must be at least 1");
      end
      if (BACKOFF_CYCLES < 1) begin : g_bad_backoff
         $error("BACKOFF_CYCLES must be at least 1");
      end
   endgenerate

   st_e              state;
   logic             is_wr, recover;
   logic [7:0]       dev_q, off_q, wd_q, rd_q;
   logic [IDX_W-1:0] idx;
   logic [SUB_W-1:0] sub;
   logic [TRY_W-1:0] tries, limit;
   logic             done_q, fail_q, bb_q;

   item_t item;
   prim_e p_op;
   logic  p_bit, p_last, p_chk, p_rx;
   logic  bo_load, bo_exp, abort_now;

   i2c_regseq_script u_script (
      .recover (recover),
      .is_wr   (is_wr),
      .idx     (idx),
      .item    (item)
   );

   i2c_regseq_prim #(.CLR_PULSES(CLR_PULSES), .SUB_W(SUB_W)) u_prim (
      .item (item),
      .sub  (sub),
      .dev  (dev_q),
      .off  (off_q),
      .wd   (wd_q),
      .op   (p_op),
      .bitv (p_bit),
      .last (p_last),
      .chk  (p_chk),
      .rx   (p_rx)
   );

   i2c_regseq_backoff #(.CYCLES(BACKOFF_CYCLES)) u_backoff (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (bo_load),
      .expired (bo_exp)
   );

   assign limit      = is_wr ? TRY_W'(WRITE_TRIES) : TRY_W'(READ_TRIES);
   assign prim_valid = (state == ST_ISSUE) && (item.kind != IT_END);
   assign bo_load    = (state == ST_ISSUE) && (item.kind == IT_END) && recover;
   assign abort_now  = p_chk && !recover && prim_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_wr   <= 1'b0;
         recover <= 1'b0;
         dev_q   <= '0;
         off_q   <= '0;
         wd_q    <= '0;
         rd_q    <= '0;
         idx     <= '0;
         sub     <= '0;
         tries   <= '0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
         bb_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state   <= ST_ISSUE;
                  is_wr   <= req_write;
                  dev_q   <= req_dev;
                  off_q   <= req_offset;
                  wd_q    <= req_wdata;
                  recover <= 1'b0;
                  idx     <= '0;
                  sub     <= '0;
                  tries   <= '0;
                  bb_q    <= 1'b1;
                  if (!req_write) rd_q <= '0;
               end
            end
            ST_ISSUE: begin
               if (item.kind == IT_END) begin
                  if (recover) begin
                     state <= ST_BACKOFF;
                  end else begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     fail_q <= 1'b0;
                     bb_q   <= 1'b0;
                  end
               end else if (prim_done) begin
                  if (abort_now) begin
                     tries   <= tries + 1'b1;
                     recover <= 1'b1;
                     idx     <= '0;
                     sub     <= '0;
                  end else begin
                     if (p_rx) rd_q <= {rd_q[6:0], prim_rbit};
                     if (p_last) begin
                        idx <= idx + 1'b1;
                        sub <= '0;
                     end else begin
                        sub <= sub + 1'b1;
                     end
                  end
               end
            end
            ST_BACKOFF: begin
               if (bo_exp) begin
                  if (tries == limit) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     fail_q <= 1'b1;
                     bb_q   <= 1'b0;
                  end else begin
                     state   <= ST_ISSUE;
                     recover <= 1'b0;
                     idx     <= '0;
                     sub     <= '0;
                     if (!is_wr) rd_q <= '0;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign fail     = fail_q;
   assign rd_data  = rd_q;
   assign bb_en    = bb_q;
   assign prim_op  = p_op;
   assign prim_bit = p_bit;

endmodule

// File: rtl/i2c_regseq_chk.sv
module i2c_regseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       busy,
   input logic       done,
   input logic       fail,
   input logic [7:0] rd_data,
   input logic       bb_en,
   input logic       prim_valid,
   input logic [2:0] prim_op,
   input logic       prim_bit,
   input logic       prim_done
);

   // R12
   prim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prim_valid && !prim_done |=> prim_valid && $stable(prim_op) && $stable(prim_bit));

   // R8
   bb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bb_en == busy);

   // R8
   prim_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prim_valid |-> bb_en);

   // R10
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(fail));

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !req_valid |=> $stable(rd_data));

   // R6
   no_prim_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !prim_valid);

endmodule

bind i2c_regseq i2c_regseq_chk u_chk (.*);

// File: tb/i2c_regseq_tb.sv
module i2c_regseq_tb;

   localparam int BK = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [7:0] req_dev = '0, req_offset = '0, req_wdata = '0;
   logic       busy, done, fail, bb_en, prim_valid, prim_bit;
   logic [7:0] rd_data;
   logic [2:0] prim_op;
   logic       prim_done = 1'b0, prim_err = 1'b0, prim_rbit = 1'b0;

   always #4 clk = ~clk;

   i2c_regseq #(.READ_TRIES(10), .WRITE_TRIES(1), .CLR_PULSES(9), .BACKOFF_CYCLES(BK)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_dev(req_dev), .req_offset(req_offset), .req_wdata(req_wdata),
      .busy(busy), .done(done), .fail(fail), .rd_data(rd_data), .bb_en(bb_en),
      .prim_valid(prim_valid), .prim_op(prim_op), .prim_bit(prim_bit),
      .prim_done(prim_done), .prim_err(prim_err), .prim_rbit(prim_rbit)
   );

   int n_checks = 0, n_fails = 0;
   int exp_q[$];
   string cur_req = "R12";

   // behavioural line engine / target state
   int lat = 0, att = 0, ack_n = 0, wbit_n = 0, rx_n = 0, recov_cnt = 0;
   bit rec_seen = 0;
   int ab_ack[16], ab_wbit[16];
   logic [7:0] tgt = '0;
   int gap = 0, gap_n = 0;

   // expected-stream builder state
   bit aborted;
   int e_wn, e_an, e_abw, e_aba;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic serve();
      int key, want;
      key = prim_op * 2 + ((prim_op == 3'd2) ? int'(prim_bit) : 0);
      if (exp_q.size() == 0) begin
         check(1'b0, "R12", "unexpected primitive", key, -1);
      end else begin
         want = exp_q.pop_front();
         check(key == want, cur_req, "primitive code", key, want);
      end
      prim_err  = 1'b0;
      prim_rbit = 1'b0;
      case (prim_op)
         3'd2: begin wbit_n++; prim_err = (wbit_n == ab_wbit[att]); end
         3'd3: begin prim_rbit = tgt[7 - rx_n]; rx_n++; end
         3'd4: begin ack_n++; prim_err = (ack_n == ab_ack[att]); end
         3'd6: begin rec_seen = 1; prim_err = 1'b1; end
         3'd1: begin
            prim_err = 1'b1;
            if (rec_seen) begin
               rec_seen = 0; att++; ack_n = 0; wbit_n = 0; rx_n = 0; recov_cnt++;
            end
         end
         default: prim_err = 1'b1;  // START, release: errors must be ignored (R5)
      endcase
   endtask

   always @(negedge clk) begin
      if (prim_done) begin
         prim_done = 1'b0;
         prim_err  = 1'b0;
      end else if (prim_valid) begin
         if (lat < 2) lat++;
         else begin
            lat = 0;
            serve();
            prim_done = 1'b1;
         end
      end
   end

   // back-off window monitor (R6)
   always @(negedge clk) begin
      if (busy && !prim_valid) gap++;
      else begin
         if (gap > 0 && prim_valid) begin
            gap_n++;
            check(gap == BK + 1, "R6", "idle cycles before retry", gap, BK + 1);
         end
         gap = 0;
      end
   end

   function automatic void e_push(int k);
      if (!aborted) exp_q.push_back(k);
   endfunction

   function automatic void e_wbit(bit b);
      if (aborted) return;
      exp_q.push_back(4 + int'(b));
      e_wn++;
      if (e_wn == e_abw) aborted = 1;
   endfunction

   function automatic void e_ack();
      if (aborted) return;
      exp_q.push_back(8);
      e_an++;
      if (e_an == e_aba) aborted = 1;
   endfunction

   function automatic void e_byte(logic [7:0] b);
      for (int i = 7; i >= 0; i--) e_wbit(b[i]);
      e_push(10);
   endfunction

   function automatic bit e_attempt(bit wr, logic [7:0] dev, logic [7:0] off, logic [7:0] wd, int a);
      aborted = 0; e_wn = 0; e_an = 0; e_abw = ab_wbit[a]; e_aba = ab_ack[a];
      e_push(0);
      e_byte(dev); e_ack();
      e_byte(off); e_ack();
      if (wr) begin
         e_byte(wd); e_ack();
      end else begin
         e_push(0);
         e_byte({dev[7:1], 1'b1}); e_ack();
         for (int i = 0; i < 8; i++) e_push(6);
         e_wbit(1'b1);
      end
      e_push(2);
      return aborted;
   endfunction

   function automatic void e_recovery();
      exp_q.push_back(0);
      exp_q.push_back(10);
      for (int i = 0; i < 9; i++) exp_q.push_back(12);
      exp_q.push_back(0);
      exp_q.push_back(2);
   endfunction

   task automatic clear_ab();
      for (int i = 0; i < 16; i++) begin ab_ack[i] = 0; ab_wbit[i] = 0; end
   endtask

   task automatic run_op(bit wr, logic [7:0] dev, logic [7:0] off, logic [7:0] wd,
                         logic [7:0] tb_byte, bit poke, string tag);
      int limit, recs, k;
      bit efail, seen;
      limit = wr ? 1 : 10;
      cur_req = tag;
      exp_q.delete();
      efail = 1; recs = 0;
      for (int a = 0; a < limit; a++) begin
         if (!e_attempt(wr, dev, off, wd, a)) begin efail = 0; break; end
         e_recovery();
         recs++;
      end
      tgt = tb_byte; att = 0; ack_n = 0; wbit_n = 0; rx_n = 0; rec_seen = 0;
      recov_cnt = 0; gap_n = 0;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_dev = dev; req_offset = off; req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      check(busy == 1'b1, "R8", "busy after accept", busy, 1);
      check(bb_en == 1'b1, "R8", "bb_en after accept", bb_en, 1);
      if (!wr) check(rd_data == 8'h00, "R9", "rd_data cleared at read start", rd_data, 0);
      seen = 0;
      k = 0;
      while (!seen && k < 20000) begin
         if (poke && k == 30) begin
            req_valid = 1; req_write = ~wr; req_dev = 8'hFF; req_offset = 8'hEE; req_wdata = 8'h11;
         end
         if (poke && k == 31) req_valid = 0;
         @(negedge clk);
         k++;
         if (done) seen = 1;
      end
      check(seen, tag, "done pulse seen", seen, 1);
      check(fail == efail, "R10", "fail status", fail, efail);
      check(recov_cnt == recs, "R7", "recoveries run", recov_cnt, recs);
      check(gap_n == (efail ? recs - 1 : recs), "R6", "back-off windows", gap_n,
            efail ? recs - 1 : recs);
      check(exp_q.size() == 0, tag, "primitives left unissued", exp_q.size(), 0);
      check(bb_en == 1'b0, "R8", "bb_en low at done", bb_en, 0);
      if (!wr && !efail) check(rd_data == tb_byte, "R2", "read data", rd_data, tb_byte);
      repeat (20) @(negedge clk);
      if (poke) check(busy == 1'b0, "R11", "no transfer after poke", busy, 0);
      else check(busy == 1'b0, tag, "idle after done", busy, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      clear_ab();
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(busy == 0 && done == 0 && fail == 0 && bb_en == 0 && prim_valid == 0 && rd_data == 0,
            "R8", "reset state", {busy, done, fail, bb_en, prim_valid}, 0);

      // R3: clean write
      clear_ab();
      run_op(1'b1, 8'hA0, 8'h3C, 8'h5A, 8'h00, 1'b0, "R3");

      // R1 / R2: clean read, MSB-first data
      clear_ab();
      run_op(1'b0, 8'hA0, 8'h07, 8'h00, 8'hA5, 1'b0, "R1");

      // R4: abort on first ACK, then mid-offset bit, then success
      clear_ab();
      ab_ack[0]  = 1;
      ab_wbit[1] = 12;
      run_op(1'b0, 8'hA2, 8'h81, 8'h00, 8'h3C, 1'b0, "R4");

      // R5 / R7: every read attempt fails at the read-address ACK
      clear_ab();
      for (int i = 0; i < 10; i++) ab_ack[i] = 3;
      run_op(1'b0, 8'h50, 8'h10, 8'h00, 8'hFF, 1'b0, "R5");

      // R10 / R11: successful write clears fail; request poked mid-transfer
      clear_ab();
      run_op(1'b1, 8'h52, 8'hC3, 8'h96, 8'h00, 1'b1, "R10");

      // R7: write fails at data ACK, single attempt only
      clear_ab();
      ab_ack[0] = 3;
      ab_ack[1] = 3;
      run_op(1'b1, 8'h52, 8'h01, 8'h7E, 8'h00, 1'b0, "R7");

      // R9 / R12: read fails on NACK bit once, then recovers
      clear_ab();
      ab_wbit[0] = 25;
      run_op(1'b0, 8'hA0, 8'h55, 8'h00, 8'h69, 1'b0, "R12");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule